// File: doc/BRIEF.md
# Write Strobe Qualification Guard

This block sits between the raw chip-level control lines of a sector-programmable flash array and its byte loader. It decides, cycle by cycle, whether a write strobe is allowed to reach the loader. It raises a programming-allowed flag only when three conditions hold together: the digital supply-good input is high, a power-up lockout delay has run out, and output enable is not asserted.

Each of the two active-low write strobes, chip enable and write enable, passes through a synchronizer and then a minimum-width filter. A low level reaches the loader only after it has lasted a programmable number of clock cycles. A release reaches the loader in the same cycle that the synchronizer presents it. Pulses shorter than the filter width never reach the loader.

The lockout delay and the filter width are both parameters given in clock cycles. A supply drop at any point clears the lockout, and the delay then restarts from zero.

Top module: `write_guard`

## Requirements
- R1: During reset and after it, `ceCleanN` and `weCleanN` are 1 (inactive) and `progAllowed` is 0.
- R2: While `supplyOk` is 0, `progAllowed` is 0 and both cleaned strobes are 1, whatever the control lines do.
- R3: `progAllowed` can first be 1 only after `supplyOk` has been sampled high on LOCK_CYCLES consecutive clock edges. Output enable must also have been high in the synchronized view.
- R4: If `supplyOk` falls at any time, including during the lockout delay, the lockout count restarts from zero. A full LOCK_CYCLES of high samples is then needed again.
- R5: While the synchronized output enable is low (0 = asserted), `progAllowed` is 0 and both cleaned strobes stay at 1.
- R6: A cleaned strobe goes low only while both synchronized chip enable and write enable are low. Chip enable high or write enable high therefore blocks any write.
- R7: Consider a synchronized low run of chip enable or write enable shorter than MIN_LOW cycles, counted while programming is allowed. It never drives the corresponding cleaned strobe low.
- R8: Consider a synchronized low run of at least MIN_LOW cycles while programming is allowed. It drives the cleaned strobe low from the MIN_LOW-th cycle of the run onward.
- R9: When a synchronized strobe returns high, its cleaned strobe is 1 in that same cycle.
- R10: Any cycle in which programming is not allowed clears the width count. After the inhibit ends, a strobe that is still low must last a further MIN_LOW cycles before it passes.
- R11: The raw control lines reach the filter and the flag logic through SYNC_STAGES flip-flops of delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyOk | input | 1 | Synchronous supply-good indication, 1 = supply above threshold |
| ceRawN | input | 1 | Raw chip enable, active low |
| weRawN | input | 1 | Raw write enable, active low |
| oeRawN | input | 1 | Raw output enable, active low |
| ceCleanN | output | 1 | Filtered and gated chip enable for the loader, active low |
| weCleanN | output | 1 | Filtered and gated write enable for the loader, active low |
| progAllowed | output | 1 | 1 when programming may take place |

## Verification
Suppose a lockout counter or lockout flag holds the wrong value. The effect shows at `progAllowed` as an early or late rise, which is off by cycles after supply-good comes up or after a supply dip.

Suppose a width counter is wrong or fails to clear. A cleaned strobe then goes low one or more cycles early, or a short glitch leaks through as a low pulse. Such a leak is visible in the very cycle the count would reach its limit.

A broken gate shows up differently. A cleaned strobe goes low while output enable is asserted or while the other strobe is high, and this is visible within MIN_LOW cycles of the offending input reaching the end of the synchronizer.

// File: rtl/guard_pkg.sv
package guard_pkg;

  // Strobes from the control side to the filter datapath
  typedef struct packed {
    logic allow;      // programming allowed this cycle
    logic clearCnt;   // restart the width measurement
  } guardCmd_t;

endpackage

// File: rtl/guard_sync.sv
module guard_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stage;

  // First stage samples the raw input; reset to inactive (all ones)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '1;
    else       stage[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[i] <= '1;
      else       stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/guard_ctrl.sv
module guard_ctrl
  import guard_pkg::*;
#(
  parameter int LOCK_CYCLES = 2500000,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      supplyOk,
  input  logic      oeRawN,
  output logic      progAllowed,
  output guardCmd_t cmd
);

  localparam int LW = (LOCK_CYCLES > 2) ? $clog2(LOCK_CYCLES) : 1;
  localparam logic [LW-1:0] LOCK_LAST = LW'(LOCK_CYCLES - 1);

  logic          oeSyncN;
  logic [LW-1:0] lockCnt;
  logic          lockDone;

  guard_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) oe_sync_i (
    .clk (clk),
    .rstN(rstN),
    .d   (oeRawN),
    .q   (oeSyncN)
  );

  // Power-up lockout: restarts whenever the supply drops
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockCnt  <= '0;
      lockDone <= 1'b0;
    end else if (!supplyOk) begin
      lockCnt  <= '0;
      lockDone <= 1'b0;
    end else if (!lockDone) begin
      if (lockCnt == LOCK_LAST) lockDone <= 1'b1;
      else                      lockCnt  <= lockCnt + 1'b1;
    end
  end

  assign progAllowed  = supplyOk & lockDone & oeSyncN;
  assign cmd.allow    = progAllowed;
  assign cmd.clearCnt = ~progAllowed;

  // R4: a supply drop always clears the lockout on the next edge
  a_r4_restart: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> !lockDone);

  // R3: the lockout can only complete on an edge where supply was good
  a_r3_lockout_supply: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockDone) |-> $past(supplyOk));

  // R3: the counter never runs past its terminal value
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    lockCnt <= LOCK_LAST);

endmodule

// File: rtl/guard_filter.sv
module guard_filter
  import guard_pkg::*;
#(
  parameter int MIN_LOW     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      ceRawN,
  input  logic      weRawN,
  input  guardCmd_t cmd,
  output logic      ceCleanN,
  output logic      weCleanN
);

  localparam int NSTROBE = 2;   // index 0 = chip enable, 1 = write enable
  localparam int CW = (MIN_LOW > 2) ? $clog2(MIN_LOW) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(MIN_LOW - 1);

  logic [NSTROBE-1:0] syncN;
  logic [NSTROBE-1:0] lowNow;
  logic [NSTROBE-1:0] cleanN;
  logic               bothLow;

  guard_sync #(.WIDTH(NSTROBE), .STAGES(SYNC_STAGES)) strobe_sync_i (
    .clk (clk),
    .rstN(rstN),
    .d   ({weRawN, ceRawN}),
    .q   (syncN)
  );

  assign lowNow  = ~syncN;
  assign bothLow = &lowNow;

  for (genvar i = 0; i < NSTROBE; i++) begin : g_strobe
    logic [CW-1:0] widthCnt;
    logic          qualified;

    // Count consecutive low cycles; saturate at the qualifying width
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          widthCnt <= '0;
      else if (cmd.clearCnt || syncN[i])  widthCnt <= '0;
      else if (widthCnt != CNT_LAST)      widthCnt <= widthCnt + 1'b1;
    end

    assign qualified = (widthCnt == CNT_LAST);
    assign cleanN[i] = ~(qualified & bothLow & cmd.allow);

    // R9: a release at the synchronizer output is seen at once
    a_r9_release: assert property (@(posedge clk) disable iff (!rstN)
      $rose(syncN[i]) |-> cleanN[i]);

    // R6: a cleaned low needs both synchronized strobes low
    a_r6_both_low: assert property (@(posedge clk) disable iff (!rstN)
      !cleanN[i] |-> (lowNow == 2'b11));

    if (MIN_LOW > 1) begin : g_width
      // R7: a cleaned low implies the strobe was already low and allowed one cycle earlier
      a_r7_min_width: assert property (@(posedge clk) disable iff (!rstN)
        !cleanN[i] |-> ($past(lowNow[i]) && $past(cmd.allow)));
    end
  end

  assign ceCleanN = cleanN[0];
  assign weCleanN = cleanN[1];

endmodule

// File: rtl/write_guard.sv
module write_guard
  import guard_pkg::*;
#(
  parameter int LOCK_CYCLES = 2500000,
  parameter int MIN_LOW     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyOk,
  input  logic ceRawN,
  input  logic weRawN,
  input  logic oeRawN,
  output logic ceCleanN,
  output logic weCleanN,
  output logic progAllowed
);

  guardCmd_t cmd;

  guard_ctrl #(.LOCK_CYCLES(LOCK_CYCLES), .SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .supplyOk   (supplyOk),
    .oeRawN     (oeRawN),
    .progAllowed(progAllowed),
    .cmd        (cmd)
  );

  guard_filter #(.MIN_LOW(MIN_LOW), .SYNC_STAGES(SYNC_STAGES)) filter_i (
    .clk     (clk),
    .rstN    (rstN),
    .ceRawN  (ceRawN),
    .weRawN  (weRawN),
    .cmd     (cmd),
    .ceCleanN(ceCleanN),
    .weCleanN(weCleanN)
  );

  // R2/R5: no cleaned strobe ever reaches the loader without permission
  a_r2_gate: assert property (@(posedge clk) disable iff (!rstN)
    (!ceCleanN || !weCleanN) |-> progAllowed);

  // R2: without supply there is never permission
  a_r2_supply: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |-> (ceCleanN && weCleanN && !progAllowed));

endmodule

// File: tb/write_guard_tb_top.sv
module write_guard_tb_top;

  localparam int LOCK = 24;
  localparam int MINW = 4;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyOk = 1'b0;
  logic ceRawN = 1'b1, weRawN = 1'b1, oeRawN = 1'b1;
  logic ceCleanN, weCleanN, progAllowed;

  int total = 0;
  int bad = 0;
  string curReq = "R1";

  always #2 clk = ~clk;   // 250 MHz

  write_guard #(.LOCK_CYCLES(LOCK), .MIN_LOW(MINW), .SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk),
    .ceRawN(ceRawN), .weRawN(weRawN), .oeRawN(oeRawN),
    .ceCleanN(ceCleanN), .weCleanN(weCleanN), .progAllowed(progAllowed)
  );

  // Reference model built from the requirements
  logic [SYNC-1:0] mCe = '1, mWe = '1, mOe = '1;
  int  mLockCnt = 0;
  bit  mLockDone = 0;
  int  mCntCe = 0, mCntWe = 0;

  function automatic bit expAllowed();
    return supplyOk && mLockDone && mOe[SYNC-1];
  endfunction

  function automatic bit expClean(int cnt);
    return !((cnt == MINW-1) && !mCe[SYNC-1] && !mWe[SYNC-1] && expAllowed());
  endfunction

  function automatic int nextCnt(int cnt, bit syncHigh, bit allowPre);
    if (!allowPre || syncHigh) return 0;
    if (cnt < MINW-1) return cnt + 1;
    return cnt;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCe = '1; mWe = '1; mOe = '1;
      mLockCnt = 0; mLockDone = 0; mCntCe = 0; mCntWe = 0;
    end else begin
      bit allowPre;
      allowPre = expAllowed();
      mCntCe = nextCnt(mCntCe, mCe[SYNC-1], allowPre);
      mCntWe = nextCnt(mCntWe, mWe[SYNC-1], allowPre);
      if (!supplyOk) begin
        mLockCnt = 0; mLockDone = 0;
      end else if (!mLockDone) begin
        if (mLockCnt == LOCK-1) mLockDone = 1;
        else mLockCnt = mLockCnt + 1;
      end
      mCe = {mCe[SYNC-2:0], ceRawN};
      mWe = {mWe[SYNC-2:0], weRawN};
      mOe = {mOe[SYNC-2:0], oeRawN};
    end
  end

  task automatic checkOne(string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", curReq, what, act, exp, $time);
    end
  endtask

  task automatic doCheck();
    checkOne("progAllowed", progAllowed, expAllowed());
    checkOne("ceCleanN", ceCleanN, expClean(mCntCe));
    checkOne("weCleanN", weCleanN, expClean(mCntWe));
  endtask

  // Set inputs just after a negedge, then check each following negedge
  task automatic apply(bit s, bit ce, bit we, bit oe, int n);
    supplyOk = s; ceRawN = ce; weRawN = we; oeRawN = oe;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      doCheck();
    end
  endtask

  int firstAllowed;

  initial begin
    // R1: reset state
    curReq = "R1";
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      checkOne("ceCleanN", ceCleanN, 1'b1);
      checkOne("weCleanN", weCleanN, 1'b1);
      checkOne("progAllowed", progAllowed, 1'b0);
    end
    rstN = 1'b1;

    // R2: no supply, strobes held low long
    curReq = "R2";
    apply(0, 0, 0, 1, 12);
    apply(0, 1, 1, 1, 2);

    // R3: lockout measured from supply rise; R11 latency on control lines
    curReq = "R3";
    supplyOk = 1; ceRawN = 1; weRawN = 1; oeRawN = 1;
    firstAllowed = -1;
    for (int k = 0; k < LOCK + 6; k++) begin
      @(negedge clk);
      doCheck();
      if (progAllowed && firstAllowed < 0) firstAllowed = k;
    end
    total++;
    if (firstAllowed != LOCK - 1) begin
      bad++;
      $display("FAIL R3 first allowed cycle actual=%0d expected=%0d", firstAllowed, LOCK - 1);
    end

    // R4: supply dip mid-lockout restarts the count
    curReq = "R4";
    apply(0, 1, 1, 1, 1);
    apply(1, 1, 1, 1, LOCK / 2);
    apply(0, 1, 1, 1, 2);
    apply(1, 1, 1, 1, LOCK + 4);

    // R8 and R11: long write pulse passes after MIN_LOW synchronized cycles
    curReq = "R8";
    apply(1, 0, 0, 1, MINW + SYNC + 5);
    // R9: immediate release
    curReq = "R9";
    apply(1, 1, 0, 1, SYNC + 2);
    apply(1, 1, 1, 1, 3);

    // R7: short pulses of every length below the limit
    curReq = "R7";
    for (int w = 1; w < MINW; w++) begin
      apply(1, 0, 0, 1, w);
      apply(1, 1, 1, 1, SYNC + 3);
    end

    // R6: one strobe low alone never passes
    curReq = "R6";
    apply(1, 1, 0, 1, MINW + SYNC + 4);
    apply(1, 0, 1, 1, MINW + SYNC + 4);
    apply(1, 1, 1, 1, 3);

    // R5: output enable asserted blocks everything
    curReq = "R5";
    apply(1, 0, 0, 0, MINW + SYNC + 4);
    // R10: inhibit ends with strobes still low; count restarts
    curReq = "R10";
    apply(1, 0, 0, 1, MINW + SYNC + 4);
    apply(1, 1, 1, 1, 4);

    // Random mix of pulses, inhibits and supply dips
    curReq = "R8";
    void'($urandom(32'h5EED_0042));
    begin
      bit s = 1, ce = 1, we = 1, oe = 1;
      for (int k = 0; k < 4000; k++) begin
        if ($urandom_range(0, 255) == 0) s = 0; else if ($urandom_range(0, 7) == 0) s = 1;
        if ($urandom_range(0, 3) == 0) ce = ~ce;
        if ($urandom_range(0, 3) == 0) we = ~we;
        if ($urandom_range(0, 1) == 0) begin ce = we; end
        oe = ($urandom_range(0, 19) != 0);
        apply(s, ce, we, oe, 1);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired in %s", curReq);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule